// File: doc/BRIEF.md
# DRAM Cycle-Type Decoder

This block observes the control strobes of an asynchronous DRAM port and names the kind of memory cycle in progress. The strobes are row strobe, one column strobe per byte lane, write enable and output enable, all active low and sampled on a system clock. The names it gives are standby, read, early write, delayed write, read-modify-write, column-before-row refresh and row-only refresh. It also reports, for each byte lane, whether that lane is being written and whether its data output should be driven. It can serve as a protocol monitor on a memory bus, or as the control front end of a behavioural DRAM model that supplies the storage array itself.

The cycle class comes from the union of the column strobes. The first lane strobe to fall opens a column access and decides its class. The access closes only when every lane strobe is high again. Write and output-drive decisions are made per lane from that lane's own strobe. All outputs are registered: they reflect the inputs sampled on the previous rising clock edge. An access that is meant as a full-width write but has lane strobes falling on different samples raises a sticky error flag.

Top module: `dram_cycle_decoder`

## Requirements
- R1: One clock after a sample with the row strobe high, `cycle_o` is 0 (standby), `lane_wr_o` and `lane_drv_o` are all zero and `skew_err_o` is low. All outputs are zero under reset.
- R2: If the row strobe falls while any lane strobe was low on the previous sample, `cycle_o` becomes 5 (column-before-row refresh) on the next clock. It keeps that value, with no lane written or driven, until the row strobe rises.
- R3: If the row strobe falls while all lane strobes were high on the previous sample, `cycle_o` becomes 6 (row-only refresh). No lane is written or driven until a lane strobe falls.
- R4: When the first lane strobe of an access falls with write enable low, `cycle_o` becomes 2 (early write) and no lane is driven.
- R5: When the first lane strobe of an access falls with write enable high, `cycle_o` becomes 1 (read). Lane i is driven while its strobe is low, output enable is low and write enable is high.
- R6: In a read access, write enable may fall while a lane strobe is low. If output enable has not been low since the access opened, `cycle_o` becomes 3 (delayed write) and no lane is driven.
- R7: In the same situation, if output enable was low at some sample since the access opened, `cycle_o` becomes 4 (read-modify-write).
- R8: Once the first lane strobe has fallen, the class stays fixed while the row strobe stays low. A later lane fall within the same access does not change it, and neither does the rise of all lane strobes. Only a new first fall after all lanes were high can change it (page-mode access).
- R9: In a write class (2, 3, 4), `lane_wr_o[i]` is high one clock after a sample where lane strobe i and write enable are both low. A lane whose strobe is high is never written or driven. Bit 0 is the lower byte lane and bit 1 the upper.
- R10: `skew_err_o` goes high when a lane strobe falls while another lane strobe was already low and write enable is low, outside refresh. It stays high until the row strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | LANES (2) | Per-lane column strobes, active low, bit 0 lower byte |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| cycle_o | output | 3 | Cycle class code (0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 column-before-row refresh, 6 row-only refresh) |
| lane_wr_o | output | LANES (2) | Lane written this sample |
| lane_drv_o | output | LANES (2) | Lane output driven this sample |
| skew_err_o | output | 1 | Staggered lane strobes during a write |

## Verification
The hardest case to reach is telling a read-modify-write from a delayed write. Both begin as reads and differ only in whether output enable pulsed low before write enable fell. The stimulus opens a read access, optionally pulses output enable over a few samples, and then drops write enable with the lane strobes still low. Staggered lane strobes are produced by dropping one lane a sample before the other, with write enable both low and high. Page-mode reclassification is reached by raising both lanes and opening a new access under the same row strobe.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [2:0] {
    CYC_STANDBY    = 3'd0,
    CYC_READ       = 3'd1,
    CYC_EARLY_WR   = 3'd2,
    CYC_DELAYED_WR = 3'd3,
    CYC_RMW        = 3'd4,
    CYC_CBR        = 3'd5,
    CYC_RAS_ONLY   = 3'd6
  } cyc_e;

  function automatic logic cyc_is_write(cyc_e c);
    return (c == CYC_EARLY_WR) || (c == CYC_DELAYED_WR) || (c == CYC_RMW);
  endfunction

  function automatic logic cyc_may_drive(cyc_e c);
    return (c == CYC_READ) || (c == CYC_RMW);
  endfunction
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic [LANES-1:0] cas_ni,
  input  logic             we_ni,
  output logic             ras_fall_o,
  output logic [LANES-1:0] cas_fall_o,
  output logic [LANES-1:0] cas_prev_low_o,
  output logic             we_fall_o
);
  logic ras_q, we_q;
  logic [LANES-1:0] cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_ni;
      we_q  <= we_ni;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cas_q[i] <= 1'b1;
      else         cas_q[i] <= cas_ni[i];
    end
    assign cas_fall_o[i]     = cas_q[i] & ~cas_ni[i];
    assign cas_prev_low_o[i] = ~cas_q[i];
  end

  assign ras_fall_o = ras_q & ~ras_ni;
  assign we_fall_o  = we_q & ~we_ni;
endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier
  import dram_cyc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic [LANES-1:0] cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic             ras_fall_i,
  input  logic [LANES-1:0] cas_fall_i,
  input  logic [LANES-1:0] cas_prev_low_i,
  input  logic             we_fall_i,
  output cyc_e             cls_next_o,
  output cyc_e             cls_o,
  output logic             skew_err_o
);
  cyc_e cls_q, cls_d;
  logic oe_seen_q, oe_seen_d;
  logic err_q, err_d;
  logic any_low, prev_any_low, access_open, late_fall;

  assign any_low      = |(~cas_ni);
  assign prev_any_low = |cas_prev_low_i;
  assign access_open  = ~prev_any_low & any_low;
  assign late_fall    = (|cas_fall_i) & prev_any_low;

  always_comb begin
    cls_d = cls_q;
    if (ras_ni)                cls_d = CYC_STANDBY;
    else if (ras_fall_i)       cls_d = prev_any_low ? CYC_CBR : CYC_RAS_ONLY;
    else if (cls_q == CYC_CBR) cls_d = CYC_CBR;
    else if (access_open)      cls_d = we_ni ? CYC_READ : CYC_EARLY_WR;
    else if (cls_q == CYC_READ && we_fall_i && any_low)
      cls_d = oe_seen_q ? CYC_RMW : CYC_DELAYED_WR;
  end

  always_comb begin
    oe_seen_d = oe_seen_q;
    if (ras_ni)           oe_seen_d = 1'b0;
    else if (access_open) oe_seen_d = ~oe_ni;
    else if (cls_d == CYC_READ && any_low && !oe_ni) oe_seen_d = 1'b1;
  end

  always_comb begin
    if (ras_ni) err_d = 1'b0;
    else        err_d = err_q | ((cls_d != CYC_CBR) & ~we_ni & late_fall);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q     <= CYC_STANDBY;
      oe_seen_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cls_q     <= cls_d;
      oe_seen_q <= oe_seen_d;
      err_q     <= err_d;
    end
  end

  assign cls_next_o = cls_d;
  assign cls_o      = cls_q;
  assign skew_err_o = err_q;

  assert_cbr_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && prev_any_low) |=> (cls_q == CYC_CBR));
  assert_row_only_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && !prev_any_low) |=> (cls_q == CYC_RAS_ONLY));
  assert_class_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && !ras_fall_i && !access_open && !we_fall_i) |=> $stable(cls_q));
  assert_skew_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !ras_ni) |=> err_q);
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import dram_cyc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cyc_e             cls_next_i,
  input  logic             ras_ni,
  input  logic [LANES-1:0] cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  output logic [LANES-1:0] wr_o,
  output logic [LANES-1:0] drv_o
);
  logic wr_ok, drv_ok;
  assign wr_ok  = ~ras_ni & ~we_ni & cyc_is_write(cls_next_i);
  assign drv_ok = ~ras_ni & we_ni & ~oe_ni & cyc_may_drive(cls_next_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_o[i]  <= 1'b0;
        drv_o[i] <= 1'b0;
      end else begin
        wr_o[i]  <= wr_ok & ~cas_ni[i];
        drv_o[i] <= drv_ok & ~cas_ni[i];
      end
    end

    assert_own_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cas_ni[i] |=> (!wr_o[i] && !drv_o[i]));
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_cyc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic [LANES-1:0] cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  output logic [2:0]       cycle_o,
  output logic [LANES-1:0] lane_wr_o,
  output logic [LANES-1:0] lane_drv_o,
  output logic             skew_err_o
);
  logic             ras_fall, we_fall;
  logic [LANES-1:0] cas_fall, cas_prev_low;
  cyc_e             cls_next, cls_cur;

  strobe_sampler #(.LANES(LANES)) u_sampler (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni,
    .ras_fall_o(ras_fall), .cas_fall_o(cas_fall),
    .cas_prev_low_o(cas_prev_low), .we_fall_o(we_fall)
  );

  cycle_classifier #(.LANES(LANES)) u_class (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni,
    .ras_fall_i(ras_fall), .cas_fall_i(cas_fall),
    .cas_prev_low_i(cas_prev_low), .we_fall_i(we_fall),
    .cls_next_o(cls_next), .cls_o(cls_cur), .skew_err_o(skew_err_o)
  );

  lane_ctrl #(.LANES(LANES)) u_lanes (
    .clk_i, .rst_ni, .cls_next_i(cls_next), .ras_ni, .cas_ni, .we_ni, .oe_ni,
    .wr_o(lane_wr_o), .drv_o(lane_drv_o)
  );

  assign cycle_o = cls_cur;

  assert_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_ni |=> (cycle_o == 3'd0 && lane_wr_o == '0 && lane_drv_o == '0 && !skew_err_o));
  assert_write_class_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_wr_o) |-> (cycle_o == 3'd2 || cycle_o == 3'd3 || cycle_o == 3'd4));
  assert_drive_class_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_drv_o) |-> (cycle_o == 3'd1 || cycle_o == 3'd4));
  assert_refresh_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == 3'd5 || cycle_o == 3'd6) |-> (lane_wr_o == '0 && lane_drv_o == '0));
  assert_no_wr_drv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr_o & lane_drv_o) == '0);
endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  logic clk = 0, rst_ni = 0;
  logic ras_ni = 1, we_ni = 1, oe_ni = 1;
  logic [1:0] cas_ni = 2'b11;
  logic [2:0] cycle_o;
  logic [1:0] lane_wr_o, lane_drv_o;
  logic skew_err_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cycle_decoder uut (.clk_i(clk), .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni,
                          .cycle_o, .lane_wr_o, .lane_drv_o, .skew_err_o);

  // behavioural reference
  int m_cls = 0, m_wr = 0, m_drv = 0, m_err = 0, m_oes = 0;
  int p_r = 1, p_l = 1, p_u = 1, p_w = 1;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cls = 0; m_wr = 0; m_drv = 0; m_err = 0; m_oes = 0;
      p_r = 1; p_l = 1; p_u = 1; p_w = 1;
    end else begin
      int r, l, u, w, o, nc, lo_now, lo_prev, opened, late;
      r = ras_ni; l = cas_ni[0]; u = cas_ni[1]; w = we_ni; o = oe_ni;
      lo_now = (l == 0 || u == 0); lo_prev = (p_l == 0 || p_u == 0);
      opened = !lo_prev && lo_now;
      late = ((p_l && !l) || (p_u && !u)) && lo_prev;
      if (r) nc = 0;
      else if (p_r && !r) nc = lo_prev ? 5 : 6;
      else if (m_cls == 5) nc = 5;
      else if (opened) nc = w ? 1 : 2;
      else if (m_cls == 1 && p_w && !w && lo_now) nc = m_oes ? 4 : 3;
      else nc = m_cls;
      if (r) m_oes = 0;
      else if (opened) m_oes = !o;
      else if (nc == 1 && lo_now && !o) m_oes = 1;
      m_wr = 0; m_drv = 0;
      if (!r && !w && (nc == 2 || nc == 3 || nc == 4)) m_wr = (l ? 0 : 1) + (u ? 0 : 2);
      if (!r && w && !o && (nc == 1 || nc == 4)) m_drv = (l ? 0 : 1) + (u ? 0 : 2);
      m_err = r ? 0 : (m_err || (nc != 5 && !w && late));
      m_cls = nc;
      p_r = r; p_l = l; p_u = u; p_w = w;
    end
  end

  function automatic string cls_tag(int c);
    case (c)
      0: return "R1"; 1: return "R5"; 2: return "R4"; 3: return "R6";
      4: return "R7"; 5: return "R2"; default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk({cls_tag(m_cls), " model cycle"}, cycle_o, m_cls);
    chk("R9 model lane_wr", lane_wr_o, m_wr);
    chk("R5 model lane_drv", lane_drv_o, m_drv);
    chk("R10 model skew", skew_err_o, m_err);
  end

  // drive after negedge, return just after the capturing posedge
  task automatic tick(input bit r, input bit l, input bit u, input bit w, input bit o);
    @(negedge clk); #1;
    ras_ni = r; cas_ni = {u, l}; we_ni = w; oe_ni = o;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #13;
    chk("R1 reset cycle", cycle_o, 0);
    chk("R1 reset lanes", {lane_wr_o, lane_drv_o}, 0);
    rst_ni = 1;
    tick(1,1,1,1,1); tick(1,0,0,0,0);
    chk("R1 standby ignores strobes", {cycle_o, lane_wr_o, lane_drv_o, skew_err_o}, 0);
    // column-before-row refresh
    tick(1,0,1,1,1); tick(0,0,1,1,0); chk("R2 cbr entry", cycle_o, 5);
    tick(0,0,0,0,0); tick(0,1,1,1,1); tick(0,0,0,1,0);
    chk("R2 cbr held", cycle_o, 5);
    chk("R2 cbr quiet", {lane_wr_o, lane_drv_o}, 0);
    tick(1,1,1,1,1); chk("R1 back to standby", cycle_o, 0);
    // row-only refresh
    tick(0,1,1,1,0); tick(0,1,1,1,0); chk("R3 row only", cycle_o, 6);
    chk("R3 row only quiet", lane_drv_o, 0);
    // early write, word
    tick(0,0,0,0,1); chk("R4 early write", cycle_o, 2);
    chk("R4 word written", lane_wr_o, 3); chk("R4 no drive", lane_drv_o, 0);
    tick(1,1,1,1,1);
    // read word then byte (page mode)
    tick(0,1,1,1,1); tick(0,0,0,1,0); chk("R5 read", cycle_o, 1);
    chk("R5 word driven", lane_drv_o, 3);
    tick(0,1,1,1,0); chk("R8 held after last rise", cycle_o, 1);
    tick(0,0,1,1,0); chk("R9 lower only driven", lane_drv_o, 1);
    tick(0,1,1,1,0); tick(0,1,0,0,1); chk("R8 page reclassify", cycle_o, 2);
    chk("R9 upper only written", lane_wr_o, 2);
    tick(1,1,1,1,1);
    // delayed write
    tick(0,1,1,1,1); tick(0,0,0,1,1); tick(0,0,0,0,1);
    chk("R6 delayed write", cycle_o, 3); chk("R6 no drive", lane_drv_o, 0);
    chk("R6 written", lane_wr_o, 3);
    tick(1,1,1,1,1);
    // read-modify-write
    tick(0,1,1,1,1); tick(0,0,0,1,1); tick(0,0,0,1,0);
    chk("R7 read phase drives", lane_drv_o, 3);
    tick(0,0,0,1,1); tick(0,0,0,0,1);
    chk("R7 rmw", cycle_o, 4); chk("R7 rmw written", lane_wr_o, 3);
    tick(1,1,1,1,1);
    // staggered write strobes
    tick(0,1,1,1,1); tick(0,0,1,0,1); chk("R10 no error on first", skew_err_o, 0);
    tick(0,0,0,0,1); chk("R10 skew flagged", skew_err_o, 1);
    chk("R8 second fall keeps class", cycle_o, 2);
    tick(0,1,1,1,1); chk("R10 skew held", skew_err_o, 1);
    tick(1,1,1,1,1); chk("R10 cleared by row rise", skew_err_o, 0);
    // staggered read: no error
    tick(0,1,1,1,1); tick(0,1,0,1,0); tick(0,0,0,1,0);
    chk("R10 staggered read ok", skew_err_o, 0);
    tick(1,1,1,1,1); tick(1,1,1,1,1);
    finish_run();
  end
endmodule